// File: doc/BRIEF.md
# Upset-Tolerant Serial Pattern Detector

This block watches a one-bit serial stream and raises a one-cycle hit when the most recent sixteen bits equal a fixed pattern. Its sixteen states count how many leading pattern bits have been seen so far. On a mismatch the machine falls back to the longest part of the pattern that still lines up, so overlapping occurrences are all found. The state register holds an error-correcting codeword instead of a plain count. Every pair of legal codewords differs in at least four bit positions, so any single flipped bit is repaired before the next-state logic uses it.

A fault-injection input flips chosen bits of the value being written into the state register. A single flipped bit is corrected on the following clock and leaves the hit output exactly as it would have been. Two flipped bits cannot be repaired. In that case the machine drops back to idle and starts looking for the pattern again. Either event raises a one-cycle upset flag. The block suits control paths that must keep running through radiation-induced upsets while behaving the same as an unprotected detector.

Top module: `seqdet_d3`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine is loaded with the idle state (the all-zero codeword), and `match_o` and `err_o` read 0 after that edge.
- R2: Bits arrive on `din`, one per clock, with the first bit of an occurrence compared to `PATTERN[PLEN-1]` and the last to `PATTERN[0]`. `match_o` is high for exactly the one cycle following the edge that samples a bit completing a run of `PLEN` bits equal to `PATTERN`. Otherwise it is low.
- R3: Overlapping occurrences are all reported. A bit may count both as the tail of one occurrence and as part of the head of the next.
- R4: A match requires all `PLEN` bits to have been received since the last reset or forced return to idle. Bits from before that point never count toward a match.
- R5: Bit i of `fault_mask` flips bit i of the codeword written into the state register at that edge (it is ignored while `rst` is high). Any mask with exactly one bit set, applied at any cycle (including every cycle in a row), leaves the `match_o` sequence unchanged.
- R6: When the register holds a codeword with one flipped bit, the next edge corrects it and sets `err_o` for the following cycle. So a single-bit mask sampled at edge k gives `err_o` high after edge k+1.
- R7: When the register holds a codeword with two flipped bits, the next edge discards the `din` bit sampled there. It forces idle, keeps `match_o` low and sets `err_o`. Detection then restarts from zero received bits.
- R8: A non-zero `fault_mask` held during reset has no effect. The first cycles after reset show no upset flag, and matching proceeds normally.
- R9: The codeword is an extended Hamming code. Bit 0 holds overall even parity. Bits at power-of-two positions 1, 2 and 4 hold check bits. Bits 3, 5, 6 and 7 hold the state value, least significant bit first. For `PLEN`=16 the codeword is 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, sampled every clock |
| fault_mask | input | CW (8 by default) | Bits XORed into the next state codeword, for fault injection |
| match_o | output | 1 | One-cycle pulse on a completed pattern occurrence |
| err_o | output | 1 | One-cycle pulse when a corrupted state codeword was seen |

## Verification
The bench builds the block with `PLEN`=16 and `PATTERN`=16'h9B9B. That pattern repeats after eight bits, so back-to-back overlapping hits and KMP-style fallbacks into the middle of the pattern are exercised. The default 8-bit codeword lets the bench walk a single flip through every register bit, including the overall parity bit, while patterns are in flight. It also injects flips on consecutive cycles and two-bit flips that must force a restart. A behavioural model keeps the last sixteen bits and a count of bits since the last restart, and checks both outputs on every clock.

// File: rtl/seqdet_d3_pkg.sv
package seqdet_d3_pkg;

    // Outcome of checking one stored codeword
    typedef enum logic [1:0] {
        DEC_CLEAN = 2'd0,
        DEC_FIXED = 2'd1,
        DEC_LOST  = 2'd2
    } dec_stat_e;

    // Smallest number of Hamming check bits covering dw data bits
    function automatic int check_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < (dw + r + 1)) begin
            r++;
        end
        return r;
    endfunction

endpackage

// File: rtl/d3_encoder.sv
module d3_encoder #(
    parameter int DW = 4,
    parameter int RB = 3,
    localparam int N = DW + RB
) (
    input  logic [DW-1:0] data_i,
    output logic [N:0]    code_o
);

    always_comb begin
        logic [N:0] cw;
        logic       par;
        int         k;
        cw = '0;
        k  = 0;
        // data occupies every position that is not a power of two
        for (int p = 1; p <= N; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = data_i[k];
                k++;
            end
        end
        // check bit at position 2^i covers positions with bit i set
        for (int i = 0; i < RB; i++) begin
            par = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if ((((p >> i) & 1) != 0) && (p != (1 << i))) begin
                    par = par ^ cw[p];
                end
            end
            cw[1 << i] = par;
        end
        cw[0]  = ^cw[N:1];
        code_o = cw;
    end

endmodule

// File: rtl/d3_decoder.sv
module d3_decoder
    import seqdet_d3_pkg::*;
#(
    parameter int DW = 4,
    parameter int RB = 3,
    localparam int N = DW + RB
) (
    input  logic [N:0]    code_i,
    output logic [DW-1:0] data_o,
    output dec_stat_e     stat_o
);

    always_comb begin
        logic [RB-1:0] syn;
        logic          par;
        logic [N:0]    fixed;
        int            k;
        syn = '0;
        for (int p = 1; p <= N; p++) begin
            if (code_i[p]) begin
                syn = syn ^ RB'(p);
            end
        end
        par    = ^code_i;
        fixed  = code_i;
        stat_o = DEC_CLEAN;
        if (par) begin
            // odd number of flips: one bit, located by the syndrome
            if (int'(syn) <= N) begin
                fixed[syn] = ~fixed[syn];
                stat_o     = DEC_FIXED;
            end else begin
                stat_o = DEC_LOST;
            end
        end else if (syn != '0) begin
            // even parity with a syndrome: two flips, not repairable
            stat_o = DEC_LOST;
        end
        data_o = '0;
        k      = 0;
        for (int p = 1; p <= N; p++) begin
            if ((p & (p - 1)) != 0) begin
                data_o[k] = fixed[p];
                k++;
            end
        end
    end

endmodule

// File: rtl/d3_walk_table.sv
module d3_walk_table #(
    parameter int PLEN = 16,
    parameter logic [PLEN-1:0] PATTERN = 16'hE5A3,
    localparam int SW   = $clog2(PLEN),
    localparam int ROWS = 1 << SW
) (
    input  logic [SW-1:0] state_i,
    input  logic          bit_i,
    output logic [SW-1:0] next_o,
    output logic          hit_o
);

    // Longest pattern prefix that is a suffix of (prefix of length s) + b,
    // capped below PLEN so a full hit falls back to its border
    function automatic int step_len(input int s, input int b);
        int   n;
        int   best;
        int   pos;
        logic ok;
        logic w;
        n    = s + 1;
        best = 0;
        for (int len = 1; len <= n && len < PLEN; len++) begin
            ok = 1'b1;
            for (int j = 0; j < len; j++) begin
                pos = n - len + j;
                w   = (pos < s) ? PATTERN[PLEN-1-pos] : b[0];
                if (w != PATTERN[PLEN-1-j]) begin
                    ok = 1'b0;
                end
            end
            if (ok) begin
                best = len;
            end
        end
        return best;
    endfunction

    logic [SW-1:0] tab [ROWS*2];

    for (genvar s = 0; s < ROWS; s++) begin : g_row
        for (genvar b = 0; b < 2; b++) begin : g_bit
            localparam int NX = (s < PLEN) ? step_len(s, b) : 0;
            assign tab[s*2+b] = SW'(NX);
        end
    end

    always_comb begin
        next_o = tab[{state_i, bit_i}];
        hit_o  = (int'(state_i) == PLEN - 1) && (bit_i == PATTERN[0]);
    end

endmodule

// File: rtl/seqdet_d3.sv
module seqdet_d3
    import seqdet_d3_pkg::*;
#(
    parameter int PLEN = 16,
    parameter logic [PLEN-1:0] PATTERN = 16'hE5A3,
    localparam int SW = $clog2(PLEN),
    localparam int RB = check_bits(SW),
    localparam int CW = SW + RB + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic [CW-1:0] fault_mask,
    output logic          match_o,
    output logic          err_o
);

    typedef struct packed {
        logic [CW-1:0] code;
        logic          match;
        logic          flag;
    } regs_t;

    regs_t         d, q;
    logic [SW-1:0] cur_state;
    dec_stat_e     dec_stat;
    logic [SW-1:0] walk_next;
    logic          walk_hit;
    logic [SW-1:0] go_state;
    logic [CW-1:0] go_code;
    logic [CW-1:0] chk_code;

    d3_decoder #(.DW(SW), .RB(RB)) u_dec (
        .code_i (q.code),
        .data_o (cur_state),
        .stat_o (dec_stat)
    );

    d3_walk_table #(.PLEN(PLEN), .PATTERN(PATTERN)) u_walk (
        .state_i (cur_state),
        .bit_i   (din),
        .next_o  (walk_next),
        .hit_o   (walk_hit)
    );

    always_comb begin
        go_state = (dec_stat == DEC_LOST) ? '0 : walk_next;
    end

    d3_encoder #(.DW(SW), .RB(RB)) u_enc (
        .data_i (go_state),
        .code_o (go_code)
    );

    // re-encodes the repaired state so assertions can measure the repair
    d3_encoder #(.DW(SW), .RB(RB)) u_chk_enc (
        .data_i (cur_state),
        .code_o (chk_code)
    );

    always_comb begin
        d       = q;
        d.code  = go_code ^ fault_mask;
        d.match = walk_hit && (dec_stat != DEC_LOST);
        d.flag  = (dec_stat != DEC_CLEAN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign match_o = q.match;
    assign err_o   = q.flag;

    p_fix_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_stat == DEC_FIXED) |-> ($countones(chk_code ^ q.code) == 1));

    p_clean_code_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(fault_mask) == '0) |-> (dec_stat == DEC_CLEAN));

    p_lost_idle_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(dec_stat == DEC_LOST) && ($past(fault_mask) == '0)) |-> (q.code == '0));

    p_lost_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_stat == DEC_LOST) |=> !match_o);

    p_hit_last_bit_r2: assert property (@(posedge clk) disable iff (rst)
        match_o |-> ($past(din) == PATTERN[0]));

    p_flag_cause_r6: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($past(fault_mask, 2) != '0));

endmodule

// File: tb/tb_seqdet_d3.sv
`timescale 1ns/1ps
module tb_seqdet_d3;

    localparam logic [15:0] PAT = 16'h9B9B;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          din = 1'b0;
    logic [CW-1:0] mask = '0;
    logic          match;
    logic          err;

    int checks = 0;
    int fails  = 0;

    // behavioural reference: last 16 bits, bits since restart, pending fault kind
    logic [15:0] hist = '0;
    int          cnt  = 0;
    int          pend = 0;
    logic        exp_m;
    logic        exp_f;
    logic [15:0] lf = 16'hACE1;

    seqdet_d3 #(.PLEN(16), .PATTERN(PAT)) dut (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .fault_mask (mask),
        .match_o    (match),
        .err_o      (err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [CW-1:0] m);
        @(negedge clk);
        rst  = 1'b1;
        mask = m;
        din  = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "match", match, 1'b0);
        chk("R1", "err", err, 1'b0);
        hist = '0;
        cnt  = 0;
        pend = 0;
    endtask

    task automatic step(input logic b, input logic [CW-1:0] m, input string req);
        @(negedge clk);
        rst  = 1'b0;
        din  = b;
        mask = m;
        if (pend == 2) begin
            hist  = '0;
            cnt   = 0;
            exp_m = 1'b0;
            exp_f = 1'b1;
        end else begin
            hist  = {hist[14:0], b};
            cnt++;
            exp_m = (cnt >= 16) && (hist == PAT);
            exp_f = (pend == 1);
        end
        pend = ($countones(m) >= 2) ? 2 : $countones(m);
        @(posedge clk);
        #1;
        chk(req, "match", match, exp_m);
        chk(req, "err", err, exp_f);
    endtask

    task automatic send_word(input logic [15:0] w, input int nbits, input string req);
        for (int i = nbits - 1; i >= 0; i--) begin
            step(w[i], '0, req);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1, R8: reset with a busy fault mask, then a clean first pattern
        do_reset(8'hFF);
        send_word(PAT, 16, "R8");
        // R2: exact pattern again after some filler
        send_word(16'h0000, 5, "R2");
        send_word(PAT, 16, "R2");
        // R3: the pattern repeats every 8 bits, so each extra half-word hits again
        send_word(PAT, 16, "R3");
        send_word(PAT, 8, "R3");
        send_word(PAT, 8, "R3");
        // R4: the tail of the pattern alone after a reset must not hit
        do_reset('0);
        send_word(PAT, 15, "R4");
        send_word(PAT, 16, "R4");
        // R2: near misses, each one bit away from the pattern
        for (int i = 0; i < 16; i++) begin
            send_word(PAT ^ (16'h1 << i), 16, "R2");
            send_word(16'h0000, 3, "R2");
        end
        // R2, R3: pseudo-random stream with embedded occurrences
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], '0, "R2");
            if ((i % 50) == 25) begin
                send_word(PAT, 16, "R3");
            end
        end
        // R5, R6: one flipped bit at every position, at many points in a pattern
        for (int rep = 0; rep < CW * 4; rep++) begin
            for (int j = 15; j >= 0; j--) begin
                if (j == ((rep * 3) % 16)) begin
                    step(PAT[j], CW'(1) << (rep % CW), "R5");
                end else begin
                    step(PAT[j], '0, "R5");
                end
            end
        end
        // R5, R6: a single flip on every cycle in a row
        for (int rep = 0; rep < 3; rep++) begin
            for (int j = 15; j >= 0; j--) begin
                step(PAT[j], CW'(1) << ((j + rep) % CW), "R6");
            end
        end
        send_word(PAT, 16, "R6");
        // R7: two flipped bits mid-pattern force a restart
        send_word(PAT, 10, "R7");
        step(PAT[5], 8'h0A, "R7");
        send_word(PAT, 5, "R7");
        send_word(PAT, 16, "R7");
        send_word(PAT, 8, "R7");
        step(PAT[7], 8'h81, "R7");
        send_word(PAT, 16, "R7");
        step(1'b1, 8'h60, "R7");
        send_word(PAT, 16, "R7");
        send_word(16'h0000, 4, "R7");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule